// File: doc/BRIEF.md
# Hardware Thread Context Selector

This block decides, once per clock, which hardware thread context feeds the next instruction fetch. Every context owns a program counter held in the block, so moving between threads needs no software save or restore. A mode input picks between two scheduling styles. In interleaved (fine) mode the selection rotates every cycle to the next eligible context in ascending index order. In switch-on-event (coarse) mode the running context keeps the fetch slot until it reports a long-latency operation, such as a second-level cache miss. The block then moves to the next eligible context and raises a one-cycle flush request so that the pipeline can be refilled.

A context that reports a long-latency event is marked stalled until a completion pulse for that context arrives. A context is eligible only when its external ready flag is high and it is not stalled. All outputs come from registers. A decision made from the inputs present before a rising edge appears at the outputs just after that edge. The context count is a parameter and may be anywhere from 2 to 128.

Top module: `thread_ctx_sel`

## Requirements
- R1: While reset is held, `sel_valid_o` and `flush_o` are 0, `sel_ctx_o` is 0 and `sel_pc_o` equals the reset PC (0 by default).
- R2: A PC write (`pc_wr_en_i`) updates the PC of `pc_wr_ctx_i` at the clock edge. `sel_pc_o` always shows the stored PC of the context on `sel_ctx_o`, including a value written at the same edge that selected it.
- R3: In fine mode (`mode_i`=0) the next selection is the first eligible context after the current one, searching upward in index and wrapping from the highest index to 0. It appears one edge after the inputs that decided it.
- R4: In fine mode, contexts with `ctx_ready_i` low or in the stalled state are skipped.
- R5: When no context is eligible, `sel_valid_o` goes to 0 at the next edge and `sel_ctx_o` keeps its value.
- R6: In coarse mode (`mode_i`=1), while the current context is not stalled, `sel_ctx_o` does not change even if other contexts are eligible. `sel_valid_o` follows that context's ready flag.
- R7: In coarse mode, a `lle_valid_i` pulse for the current context stalls it from the next edge on. At the following edge the selection moves to the next eligible context after it, with `sel_valid_o`=1 and `flush_o`=1 for exactly one cycle.
- R8: `lle_valid_i` stalls `lle_ctx_i` from the next edge, and `done_valid_i` clears `done_ctx_i` from the next edge. If both name the same context in the same cycle, the stall wins. A stalled context is never selected as valid in either mode.
- R9: In coarse mode, if the current context is stalled and no other context is eligible, the selection holds with `sel_valid_o`=0 and no flush. Once the stall is cleared, the same context resumes with `sel_valid_o`=1 and no flush.
- R10: `flush_o` is raised only when the selected context changes in coarse mode. A long-latency event for a context other than the current one causes no switch and no flush.
- R11: In fine mode `flush_o` is never raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = fine (rotate every cycle), 1 = coarse (switch on event) |
| ctx_ready_i | input | NUM_CTX | Per-context ready flag, bit i for context i |
| lle_valid_i | input | 1 | Long-latency event pulse |
| lle_ctx_i | input | CTX_W | Context reporting the event |
| done_valid_i | input | 1 | Long-latency completion pulse |
| done_ctx_i | input | CTX_W | Context whose event completed |
| pc_wr_en_i | input | 1 | PC write strobe |
| pc_wr_ctx_i | input | CTX_W | Context whose PC is written |
| pc_wr_data_i | input | PC_W | New PC value |
| sel_ctx_o | output | CTX_W | Selected context |
| sel_pc_o | output | PC_W | PC of the selected context |
| sel_valid_o | output | 1 | Selection may be fetched |
| flush_o | output | 1 | One-cycle pipeline refill request |

## Verification
A corrupted rotation pointer shows at the very next edge as a context ID out of round-robin order, because every cycle in fine mode exposes the pointer. A stall bit that is stuck set or stuck clear shows within one rotation. It appears either as a context missing from the sequence or as a valid selection of a context that has an outstanding event. In coarse mode, a wrong stall state or a wrong switch rule shows as a spurious or missing flush pulse, or as a change of context without an event, two edges after the event pulse. A corrupted PC entry shows on `sel_pc_o` as soon as that context is selected.

// File: rtl/ctxsel_pkg.sv
package ctxsel_pkg;

   typedef enum logic {
      SCHED_FINE   = 1'b0,
      SCHED_COARSE = 1'b1
   } sched_mode_e;

   localparam int unsigned MAX_CONTEXTS = 128;

endpackage

// File: rtl/ctxsel_rr_pick.sv
module ctxsel_rr_pick #(
   parameter int unsigned NUM_CTX = 8,
   localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
   input  logic [CTX_W-1:0]   cur_i,
   input  logic [NUM_CTX-1:0] elig_i,
   output logic [CTX_W-1:0]   pick_o,
   output logic               any_o
);

   localparam int unsigned IW = CTX_W + 1;

   logic [IW-1:0] idx;

   // search starts one past the current slot and ends on the current slot
   always_comb begin
      pick_o = cur_i;
      any_o  = 1'b0;
      idx    = '0;
      for (int k = 1; k <= int'(NUM_CTX); k++) begin
         idx = {1'b0, cur_i} + IW'(k);
         if (idx >= IW'(NUM_CTX)) idx = idx - IW'(NUM_CTX);
         if (!any_o && elig_i[idx[CTX_W-1:0]]) begin
            any_o  = 1'b1;
            pick_o = idx[CTX_W-1:0];
         end
      end
   end

endmodule

// File: rtl/ctxsel_stall_trk.sv
module ctxsel_stall_trk #(
   parameter int unsigned NUM_CTX = 8,
   localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_v_i,
   input  logic [CTX_W-1:0]   set_id_i,
   input  logic               clr_v_i,
   input  logic [CTX_W-1:0]   clr_id_i,
   output logic [NUM_CTX-1:0] stalled_o
);

   for (genvar g = 0; g < int'(NUM_CTX); g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     stalled_o[g] <= 1'b0;
         else if (set_v_i && set_id_i == CTX_W'(g))      stalled_o[g] <= 1'b1;
         else if (clr_v_i && clr_id_i == CTX_W'(g))      stalled_o[g] <= 1'b0;
      end
   end

   // R8: a reported event always leaves its context stalled
   a_r8_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      set_v_i |=> stalled_o[$past(set_id_i)]);

   // R8: a completion with no competing event clears the stall
   a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v_i && !(set_v_i && set_id_i == clr_id_i)) |=> !stalled_o[$past(clr_id_i)]);

endmodule

// File: rtl/ctxsel_pc_file.sv
module ctxsel_pc_file #(
   parameter int unsigned NUM_CTX = 8,
   parameter int unsigned PC_W    = 32,
   parameter logic [PC_W-1:0] RESET_PC = '0,
   localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [CTX_W-1:0] wr_id_i,
   input  logic [PC_W-1:0]  wr_data_i,
   input  logic [CTX_W-1:0] rd_id_i,
   output logic [PC_W-1:0]  rd_pc_o
);

   logic [PC_W-1:0] pc_q [NUM_CTX];

   for (genvar g = 0; g < int'(NUM_CTX); g++) begin : g_pc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   pc_q[g] <= RESET_PC;
         else if (wr_en_i && wr_id_i == CTX_W'(g))     pc_q[g] <= wr_data_i;
      end
   end

   assign rd_pc_o = pc_q[rd_id_i];

   // R2: written value lands in the addressed entry
   a_r2_pc_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> pc_q[$past(wr_id_i)] == $past(wr_data_i));

endmodule

// File: rtl/thread_ctx_sel.sv
module thread_ctx_sel
   import ctxsel_pkg::*;
#(
   parameter int unsigned NUM_CTX = 8,
   parameter int unsigned PC_W    = 32,
   parameter logic [PC_W-1:0] RESET_PC = '0,
   localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_i,
   input  logic [NUM_CTX-1:0] ctx_ready_i,
   input  logic               lle_valid_i,
   input  logic [CTX_W-1:0]   lle_ctx_i,
   input  logic               done_valid_i,
   input  logic [CTX_W-1:0]   done_ctx_i,
   input  logic               pc_wr_en_i,
   input  logic [CTX_W-1:0]   pc_wr_ctx_i,
   input  logic [PC_W-1:0]    pc_wr_data_i,
   output logic [CTX_W-1:0]   sel_ctx_o,
   output logic [PC_W-1:0]    sel_pc_o,
   output logic               sel_valid_o,
   output logic               flush_o
);

   initial begin
      a_cfg_ctx_count: assert (NUM_CTX >= 2 && NUM_CTX <= MAX_CONTEXTS);
      a_cfg_pc_width:  assert (PC_W >= 2 && PC_W <= 64);
   end

   sched_mode_e        mode;
   logic [NUM_CTX-1:0] stalled;
   logic [NUM_CTX-1:0] elig;
   logic [CTX_W-1:0]   cur_q, nxt_cur, pick;
   logic               vld_q, nxt_vld, flush_q, nxt_flush, any_elig;

   assign mode = sched_mode_e'(mode_i);
   assign elig = ctx_ready_i & ~stalled;

   ctxsel_stall_trk #(.NUM_CTX(NUM_CTX)) u_stall (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_v_i   (lle_valid_i),
      .set_id_i  (lle_ctx_i),
      .clr_v_i   (done_valid_i),
      .clr_id_i  (done_ctx_i),
      .stalled_o (stalled)
   );

   ctxsel_rr_pick #(.NUM_CTX(NUM_CTX)) u_pick (
      .cur_i  (cur_q),
      .elig_i (elig),
      .pick_o (pick),
      .any_o  (any_elig)
   );

   ctxsel_pc_file #(.NUM_CTX(NUM_CTX), .PC_W(PC_W), .RESET_PC(RESET_PC)) u_pcs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (pc_wr_en_i),
      .wr_id_i   (pc_wr_ctx_i),
      .wr_data_i (pc_wr_data_i),
      .rd_id_i   (cur_q),
      .rd_pc_o   (sel_pc_o)
   );

   always_comb begin
      nxt_cur   = cur_q;
      nxt_vld   = 1'b0;
      nxt_flush = 1'b0;
      if (mode == SCHED_FINE) begin
         if (any_elig) nxt_cur = pick;
         nxt_vld = any_elig;
      end else if (stalled[cur_q]) begin
         if (any_elig) begin
            nxt_cur   = pick;
            nxt_vld   = 1'b1;
            nxt_flush = 1'b1;
         end
      end else begin
         nxt_vld = ctx_ready_i[cur_q];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= '0;
         vld_q   <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         cur_q   <= nxt_cur;
         vld_q   <= nxt_vld;
         flush_q <= nxt_flush;
      end
   end

   assign sel_ctx_o   = cur_q;
   assign sel_valid_o = vld_q;
   assign flush_o     = flush_q;

   // R5: nothing eligible -> invalid and pointer frozen
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == '0) |=> (!sel_valid_o && $stable(sel_ctx_o)));

   // R6: coarse mode keeps a non-stalled context
   a_r6_coarse_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SCHED_COARSE && !stalled[cur_q]) |=> ($stable(sel_ctx_o) && !flush_o));

   // R7: stalled current context with an alternative forces a switch and flush
   a_r7_switch_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SCHED_COARSE && stalled[cur_q] && elig != '0) |=> (flush_o && sel_valid_o));

   // R10: a flush always accompanies a change of context
   a_r10_flush_moves: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (sel_ctx_o != $past(sel_ctx_o)));

   // R11: fine mode never requests a refill
   a_r11_fine_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SCHED_FINE) |=> !flush_o);

endmodule

// File: tb/thread_ctx_sel_tb.sv
`timescale 1ns/1ps
module thread_ctx_sel_tb;

   localparam int unsigned N  = 4;
   localparam int unsigned CW = 2;
   localparam int unsigned PW = 16;

   typedef struct {
      logic          vld;
      logic [CW-1:0] ctx;
      logic          fl;
      logic [PW-1:0] pc;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_i = 1'b0;
   logic [N-1:0]  ctx_ready_i = '0;
   logic          lle_valid_i = 1'b0;
   logic [CW-1:0] lle_ctx_i = '0;
   logic          done_valid_i = 1'b0;
   logic [CW-1:0] done_ctx_i = '0;
   logic          pc_wr_en_i = 1'b0;
   logic [CW-1:0] pc_wr_ctx_i = '0;
   logic [PW-1:0] pc_wr_data_i = '0;
   logic [CW-1:0] sel_ctx_o;
   logic [PW-1:0] sel_pc_o;
   logic          sel_valid_o;
   logic          flush_o;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   finished = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   thread_ctx_sel #(.NUM_CTX(N), .PC_W(PW)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode_i),
      .ctx_ready_i  (ctx_ready_i),
      .lle_valid_i  (lle_valid_i),
      .lle_ctx_i    (lle_ctx_i),
      .done_valid_i (done_valid_i),
      .done_ctx_i   (done_ctx_i),
      .pc_wr_en_i   (pc_wr_en_i),
      .pc_wr_ctx_i  (pc_wr_ctx_i),
      .pc_wr_data_i (pc_wr_data_i),
      .sel_ctx_o    (sel_ctx_o),
      .sel_pc_o     (sel_pc_o),
      .sel_valid_o  (sel_valid_o),
      .flush_o      (flush_o)
   );

   // monitor: compare the outputs just after each edge against the queued item
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_tests++;
         if (sel_valid_o !== e.vld || sel_ctx_o !== e.ctx || flush_o !== e.fl || sel_pc_o !== e.pc) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b ctx=%0d flush=%0b pc=%0d, expected vld=%0b ctx=%0d flush=%0b pc=%0d",
                     e.tag, sel_valid_o, sel_ctx_o, flush_o, sel_pc_o, e.vld, e.ctx, e.fl, e.pc);
         end
      end
   end

   // driver: apply one cycle of stimulus and queue the outcome expected after the edge
   task automatic step(input logic m, input logic [N-1:0] rdy,
                       input logic lv, input logic [CW-1:0] lc,
                       input logic dv, input logic [CW-1:0] dc,
                       input logic we, input logic [CW-1:0] wc, input logic [PW-1:0] wd,
                       input logic ev, input logic [CW-1:0] ec, input logic ef,
                       input logic [PW-1:0] ep, input string tag);
      exp_t e;
      @(negedge clk);
      mode_i = m; ctx_ready_i = rdy;
      lle_valid_i = lv; lle_ctx_i = lc;
      done_valid_i = dv; done_ctx_i = dc;
      pc_wr_en_i = we; pc_wr_ctx_i = wc; pc_wr_data_i = wd;
      e.vld = ev; e.ctx = ec; e.fl = ef; e.pc = ep; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_tests++;
      if (sel_valid_o !== 1'b0 || flush_o !== 1'b0 || sel_ctx_o !== '0 || sel_pc_o !== '0) begin
         n_fail++;
         $display("FAIL R1: got vld=%0b flush=%0b ctx=%0d pc=%0d, expected 0 0 0 0",
                  sel_valid_o, flush_o, sel_ctx_o, sel_pc_o);
      end
      rst_n = 1'b1;

      //    m  rdy     lv lc dv dc we wc wd     ev ec fl pc
      step(0, 4'b0000, 0, 0, 0, 0, 1, 0, 100,  0, 0, 0, 100, "R2 pc write on selected");
      step(0, 4'b0000, 0, 0, 0, 0, 1, 1, 101,  0, 0, 0, 100, "R5 idle hold");
      step(0, 4'b0000, 0, 0, 0, 0, 1, 2, 102,  0, 0, 0, 100, "R5 idle hold");
      step(0, 4'b0000, 0, 0, 0, 0, 1, 3, 103,  0, 0, 0, 100, "R2 other entry untouched");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 1, 0, 101, "R3 rotate 0->1");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 2, 0, 102, "R3 R11 rotate 1->2");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 3, 0, 103, "R3 rotate 2->3");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 0, 0, 100, "R3 wrap 3->0");
      step(0, 4'b1010, 0, 0, 0, 0, 0, 0, 0,    1, 1, 0, 101, "R4 skip to 1");
      step(0, 4'b1010, 0, 0, 0, 0, 0, 0, 0,    1, 3, 0, 103, "R4 skip 2");
      step(0, 4'b1010, 0, 0, 0, 0, 0, 0, 0,    1, 1, 0, 101, "R4 wrap skip 0");
      step(0, 4'b1111, 1, 2, 0, 0, 0, 0, 0,    1, 2, 0, 102, "R8 stall not yet active");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 3, 0, 103, "R8 rotate");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 0, 0, 100, "R8 rotate");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 1, 0, 101, "R8 rotate");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 3, 0, 103, "R4 R8 stalled ctx skipped");
      step(0, 4'b1111, 0, 0, 1, 2, 0, 0, 0,    1, 0, 0, 100, "R8 clear not yet active");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 1, 0, 101, "R8 rotate");
      step(0, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 2, 0, 102, "R8 cleared ctx selected");
      step(0, 4'b1111, 0, 0, 0, 0, 1, 3, 200,  1, 3, 0, 200, "R2 write on newly selected");
      step(1, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 3, 0, 200, "R6 coarse hold");
      step(1, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 3, 0, 200, "R6 coarse hold");
      step(1, 4'b0111, 0, 0, 0, 0, 0, 0, 0,    0, 3, 0, 200, "R6 valid follows ready");
      step(1, 4'b1111, 1, 3, 0, 0, 0, 0, 0,    1, 3, 0, 200, "R7 event latency");
      step(1, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 0, 1, 100, "R7 switch with flush");
      step(1, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 0, 0, 100, "R7 single flush pulse");
      step(1, 4'b1111, 1, 1, 0, 0, 0, 0, 0,    1, 0, 0, 100, "R10 event on other ctx");
      step(1, 4'b1111, 0, 0, 0, 0, 0, 0, 0,    1, 0, 0, 100, "R10 no switch");
      step(1, 4'b0001, 1, 0, 0, 0, 0, 0, 0,    1, 0, 0, 100, "R9 event, no alternative");
      step(1, 4'b0001, 0, 0, 0, 0, 0, 0, 0,    0, 0, 0, 100, "R9 hold invalid");
      step(1, 4'b0001, 0, 0, 1, 0, 0, 0, 0,    0, 0, 0, 100, "R9 still stalled");
      step(1, 4'b0001, 0, 0, 0, 0, 0, 0, 0,    1, 0, 0, 100, "R9 resume without flush");
      step(0, 4'b0000, 1, 2, 1, 2, 0, 0, 0,    0, 0, 0, 100, "R5 set and clear together");
      step(0, 4'b0100, 0, 0, 0, 0, 0, 0, 0,    0, 0, 0, 100, "R8 set wins over clear");
      step(0, 4'b0000, 0, 0, 1, 2, 0, 0, 0,    0, 0, 0, 100, "R5 idle");
      step(0, 4'b0100, 0, 0, 0, 0, 0, 0, 0,    1, 2, 0, 102, "R8 released ctx selected");

      @(negedge clk);
      lle_valid_i = 1'b0; done_valid_i = 1'b0; pc_wr_en_i = 1'b0;
      while (sb.size() > 0) @(negedge clk);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule